// File: doc/BRIEF.md
# Atomic memory read-modify-write unit

The unit carries out one atomic memory operation per accepted command. It reads a naturally aligned 32-bit or 64-bit word from a single-port memory. From the loaded value and a command operand it may form a new value, and it may write that value back. It then returns the loaded value, not the new one, to a register destination. The supported operations are swap, compare-and-swap, fetch-add, fetch-add that skips the store when the sum is negative, fetch-and and fetch-or. Each operation has a 32-bit and a 64-bit form.

From acceptance until the result is handed over, the unit is busy and refuses further commands. Exclusivity is modelled by this busy interval: nothing else can reach the memory between the read and the write. Faults are reported on the same done pulse as the result. The unit reports three faults: a misaligned address, an error response from memory on either access, and a destination index that maps to a network port. Registers are never written when a fault is reported. Results aimed at the hard-wired zero register or the sink register are dropped silently.

Top module: `amo_unit`

## Requirements
- R1: After reset, and whenever no command is in progress, `cmd_ready` is 1 and `busy`, `mem_req` and `done` are 0.
- R2: Every operation returns the loaded memory value on `rf_data`. In 32-bit mode (`cmd_word`=1) the loaded value is the lane picked by address bit 2 (1 selects bits 63:32 of `mem_rdata`), sign-extended from its bit 31 to 64 bits.
- R3: Swap (op 0) always stores the operand. Compare-and-swap (op 1) stores the operand only when the loaded value equals `cmd_cmp`, and otherwise leaves memory untouched. In 32-bit mode only the low 32 bits of `cmd_cmp` take part in the compare.
- R4: Fetch-add (op 2), fetch-and (op 4) and fetch-or (op 5) store the sum, AND or OR of the loaded value and the operand. Codes 6 and 7 only read.
- R5: Fetch-add-if-non-negative (op 3) stores the sum unless it is negative. The sign is bit 63 of the sum in 64-bit mode and bit 31 in 32-bit mode.
- R6: A 64-bit store drives `mem_be`=8'hFF. A 32-bit store drives 8'h0F for address bit 2 = 0 and 8'hF0 for address bit 2 = 1, so the other half of the word is kept.
- R7: A misaligned address (low two bits nonzero for 32-bit, low three bits nonzero for 64-bit) raises no memory request. The command ends with `done` and `flt_code`=1, and no register write takes place.
- R8: An error response on the read or the write ends the command with `flt_code`=2 and `flt_addr` equal to the command address. No register write and no further memory request follow, and the unit then accepts commands again.
- R9: `cmd_dst` 0 to 55 is written back. Indices 63 (zero) and 62 (sink) are dropped with no fault. Indices 56 to 61 raise `flt_code`=3 with no register write. In every one of these cases the memory part of the operation is still carried out.
- R10: After a command is accepted, `busy` is 1 and `cmd_ready` is 0 until the result is given. Commands presented in that time are not taken, and their inputs have no effect on the running operation.
- R11: Each accepted command produces exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Operation code |
| cmd_word | input | 1 | 1 = 32-bit access, 0 = 64-bit |
| cmd_addr | input | AW | Byte address |
| cmd_opnd | input | 64 | Operand |
| cmd_cmp | input | 64 | Compare value for compare-and-swap |
| cmd_dst | input | RW | Destination register index |
| busy | output | 1 | Exclusive interval in progress |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Address with the low three bits cleared |
| mem_wdata | output | 64 | Write data (a 32-bit value sits in both halves) |
| mem_be | output | 8 | Byte enables |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 64 | Read data, valid with ready |
| mem_err | input | 1 | Error response, valid with ready |
| done | output | 1 | Result and fault are valid |
| rf_we | output | 1 | Register write-back strobe |
| rf_idx | output | RW | Write-back index |
| rf_data | output | 64 | Loaded value |
| flt_code | output | 2 | 0 none, 1 misaligned, 2 access, 3 illegal register |
| flt_addr | output | AW | Address of the command that ended |

## Verification
The hardest case to reach from the ports is a second command arriving while one is still in flight. A correct unit never takes it, so the only evidence is what does not happen. The driver therefore keeps `cmd_valid` high during every operation and changes the opcode, address, operand and destination to those of a different swap. The scoreboard then shows any wrongful acceptance as an extra `done`, an extra memory request or a corrupted word. Error responses are injected per access by the memory model. This separates a failed read from a failed write after a successful read. Optional stall cycles are added while a request waits.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [2:0] {
    AMO_SWAP   = 3'd0,
    AMO_CAS    = 3'd1,
    AMO_ADD    = 3'd2,
    AMO_ADDGEZ = 3'd3,
    AMO_AND    = 3'd4,
    AMO_OR     = 3'd5
  } amo_op_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ALIGN  = 2'd1,
    FLT_ACCESS = 2'd2,
    FLT_REG    = 2'd3
  } amo_flt_e;

  typedef enum logic [1:0] {
    DST_GPR  = 2'd0,
    DST_DROP = 2'd1,
    DST_BAD  = 2'd2
  } dst_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RESP  = 3'd4
  } amo_st_e;

  // widen a 32-bit quantity by copying its top bit
  function automatic logic [DATA_W-1:0] sext_half(input logic [HALF_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v};
  endfunction

  // natural alignment for the chosen access size
  function automatic logic is_misaligned(input logic word, input logic [2:0] lo);
    if (word) return lo[1:0] != 2'b00;
    return lo != 3'b000;
  endfunction

  // value that would be stored
  function automatic logic [DATA_W-1:0] amo_store_val(
    input logic [2:0]        op,
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] opnd
  );
    logic [DATA_W-1:0] r;
    case (op)
      AMO_SWAP, AMO_CAS:  r = opnd;
      AMO_ADD, AMO_ADDGEZ: r = old_v + opnd;
      AMO_AND:            r = old_v & opnd;
      AMO_OR:             r = old_v | opnd;
      default:            r = old_v;
    endcase
    return r;
  endfunction

  // whether the store takes place
  function automatic logic amo_store_en(
    input logic [2:0]        op,
    input logic              word,
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] opnd,
    input logic [DATA_W-1:0] cmp
  );
    logic [DATA_W-1:0] sum;
    logic              eq;
    logic              neg;
    sum = old_v + opnd;
    neg = word ? sum[HALF_W-1] : sum[DATA_W-1];
    eq  = word ? (old_v[HALF_W-1:0] == cmp[HALF_W-1:0]) : (old_v == cmp);
    case (op)
      AMO_SWAP, AMO_ADD, AMO_AND, AMO_OR: return 1'b1;
      AMO_CAS:    return eq;
      AMO_ADDGEZ: return ~neg;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  logic [2:0]        op,
  input  logic              word,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write
);

  always_comb begin
    new_val  = amo_store_val(op, old_val, opnd);
    do_write = amo_store_en(op, word, old_val, opnd, cmp_val);
  end

endmodule

// File: rtl/amo_lane.sv
module amo_lane
  import amo_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          word,
  input  logic          hi,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] wval,
  output logic [DW-1:0] loaded,
  output logic [DW-1:0] wdata,
  output logic [DW/8-1:0] be
);

  localparam int NB = DW / 8;
  localparam int HB = NB / 2;
  localparam int HW = DW / 2;

  logic [HW-1:0] pick;

  always_comb begin
    pick   = hi ? rdata[DW-1:HW] : rdata[HW-1:0];
    loaded = word ? sext_half(pick) : rdata;
    wdata  = word ? {wval[HW-1:0], wval[HW-1:0]} : wval;
  end

  for (genvar i = 0; i < NB; i++) begin : g_be
    localparam logic UPPER = (i >= HB);
    assign be[i] = ~word | (hi ~^ UPPER);
  end

endmodule

// File: rtl/amo_dstcls.sv
module amo_dstcls
  import amo_pkg::*;
#(
  parameter int RW      = 6,
  parameter int NUM_GPR = 56
) (
  input  logic [RW-1:0] idx,
  output dst_cls_e      cls
);

  localparam int ZERO_IDX = (1 << RW) - 1;
  localparam int SINK_IDX = (1 << RW) - 2;

  always_comb begin
    if (int'(idx) < NUM_GPR)                            cls = DST_GPR;
    else if (int'(idx) == ZERO_IDX || int'(idx) == SINK_IDX) cls = DST_DROP;
    else                                                 cls = DST_BAD;
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int AW      = 32,
  parameter int RW      = 6,
  parameter int NUM_GPR = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_word,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DATA_W-1:0] cmd_opnd,
  input  logic [DATA_W-1:0] cmd_cmp,
  input  logic [RW-1:0]     cmd_dst,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              done,
  output logic              rf_we,
  output logic [RW-1:0]     rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic [1:0]        flt_code,
  output logic [AW-1:0]     flt_addr
);

  localparam int NB  = DATA_W / 8;
  localparam int OFF = $clog2(NB);

  amo_st_e           st;
  logic [2:0]        r_op;
  logic              r_word;
  logic [AW-1:0]     r_addr;
  logic [DATA_W-1:0] r_opnd;
  logic [DATA_W-1:0] r_cmp;
  logic [RW-1:0]     r_dst;
  logic [DATA_W-1:0] r_old;
  logic [DATA_W-1:0] r_new;
  amo_flt_e          r_flt;

  // named events for the checker
  logic accept;
  logic evt_misalign;
  logic evt_mem_err;

  logic [DATA_W-1:0] lane_loaded;
  logic [DATA_W-1:0] alu_new;
  logic              alu_wr;
  dst_cls_e          dcls;
  amo_flt_e          resp_flt;

  assign accept       = cmd_valid && (st == ST_IDLE);
  assign evt_misalign = accept && is_misaligned(cmd_word, cmd_addr[2:0]);
  assign evt_mem_err  = mem_req && mem_ready && mem_err;

  amo_lane #(.DW(DATA_W)) u_lane (
    .word   (r_word),
    .hi     (r_addr[2]),
    .rdata  (mem_rdata),
    .wval   (r_new),
    .loaded (lane_loaded),
    .wdata  (mem_wdata),
    .be     (mem_be)
  );

  amo_alu u_alu (
    .op       (r_op),
    .word     (r_word),
    .old_val  (r_old),
    .opnd     (r_opnd),
    .cmp_val  (r_cmp),
    .new_val  (alu_new),
    .do_write (alu_wr)
  );

  amo_dstcls #(.RW(RW), .NUM_GPR(NUM_GPR)) u_dcls (
    .idx (r_dst),
    .cls (dcls)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      r_op   <= '0;
      r_word <= 1'b0;
      r_addr <= '0;
      r_opnd <= '0;
      r_cmp  <= '0;
      r_dst  <= '0;
      r_old  <= '0;
      r_new  <= '0;
      r_flt  <= FLT_NONE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            r_op   <= cmd_op;
            r_word <= cmd_word;
            r_addr <= cmd_addr;
            r_opnd <= cmd_opnd;
            r_cmp  <= cmd_cmp;
            r_dst  <= cmd_dst;
            if (evt_misalign) begin
              r_flt <= FLT_ALIGN;
              st    <= ST_RESP;
            end else begin
              r_flt <= FLT_NONE;
              st    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            if (mem_err) begin
              r_flt <= FLT_ACCESS;
              st    <= ST_RESP;
            end else begin
              r_old <= lane_loaded;
              st    <= ST_CALC;
            end
          end
        end
        ST_CALC: begin
          r_new <= alu_new;
          st    <= alu_wr ? ST_WRITE : ST_RESP;
        end
        ST_WRITE: begin
          if (mem_ready) begin
            if (mem_err) r_flt <= FLT_ACCESS;
            st <= ST_RESP;
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (r_flt != FLT_NONE)   resp_flt = r_flt;
    else if (dcls == DST_BAD) resp_flt = FLT_REG;
    else                      resp_flt = FLT_NONE;
  end

  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);
  assign mem_addr  = {r_addr[AW-1:OFF], {OFF{1'b0}}};
  assign done      = (st == ST_RESP);
  assign rf_we     = done && (resp_flt == FLT_NONE) && (dcls == DST_GPR);
  assign rf_idx    = r_dst;
  assign rf_data   = r_old;
  assign flt_code  = done ? resp_flt : FLT_NONE;
  assign flt_addr  = r_addr;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int AW      = 32,
  parameter int RW      = 6,
  parameter int NUM_GPR = 56
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_be,
  input logic          done,
  input logic          rf_we,
  input logic [RW-1:0] rf_idx,
  input logic [1:0]    flt_code,
  input logic          evt_misalign,
  input logic          evt_mem_err
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done && cmd_ready));

  p_fault_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code != 2'd0) |-> !rf_we);

  p_misalign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_misalign |=> (done && !mem_req && flt_code == 2'd1));

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 8'hFF || mem_be == 8'h0F || mem_be == 8'hF0));

  p_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mem_err |=> (done && flt_code == 2'd2 && !mem_req));

  p_dst_gpr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (int'(rf_idx) < NUM_GPR));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind amo_unit amo_unit_chk #(.AW(AW), .RW(RW), .NUM_GPR(NUM_GPR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ready    (mem_ready),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .done         (done),
  .rf_we        (rf_we),
  .rf_idx       (rf_idx),
  .flt_code     (flt_code),
  .evt_misalign (evt_misalign),
  .evt_mem_err  (evt_mem_err)
);

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  localparam int AW = 32;
  localparam int RW = 6;
  localparam int NG = 56;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic          cmd_word = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [63:0]   cmd_opnd = '0;
  logic [63:0]   cmd_cmp = '0;
  logic [RW-1:0] cmd_dst = '0;
  logic          busy, mem_req, mem_we, mem_ready, mem_err;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;
  logic [7:0]    mem_be;
  logic          done, rf_we;
  logic [RW-1:0] rf_idx;
  logic [63:0]   rf_data;
  logic [1:0]    flt_code;
  logic [AW-1:0] flt_addr;

  amo_unit #(.AW(AW), .RW(RW), .NUM_GPR(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .cmd_addr(cmd_addr), .cmd_opnd(cmd_opnd),
    .cmd_cmp(cmd_cmp), .cmd_dst(cmd_dst), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err), .done(done),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .flt_code(flt_code),
    .flt_addr(flt_addr)
  );

  // memory model
  logic [63:0] mem [16];
  logic [63:0] ref_mem [16];
  logic [1:0]  stall_cfg = 2'd0;
  logic [1:0]  stall_cnt = 2'd0;
  logic        inj_rerr = 1'b0;
  logic        inj_werr = 1'b0;
  int          n_req = 0;
  int          n_wr = 0;
  logic [7:0]  last_be = 8'h00;

  assign mem_ready = mem_req && (stall_cnt == stall_cfg);
  assign mem_err   = mem_ready && (mem_we ? inj_werr : inj_rerr);
  assign mem_rdata = mem[mem_addr[6:3]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) stall_cnt <= stall_cnt + 2'd1;
    else stall_cnt <= 2'd0;
    if (mem_req && mem_ready) begin
      n_req <= n_req + 1;
      if (mem_we && !mem_err) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        n_wr    <= n_wr + 1;
        last_be <= mem_be;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic        we;
    logic [5:0]  idx;
    logic [63:0] data;
    logic [1:0]  flt;
    logic [31:0] faddr;
    logic [3:0]  wi;
    logic [63:0] mword;
    int          reqs;
    int          wrs;
    logic [7:0]  be;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_err = 0;
  int base_req = 0;
  int base_wr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(rf_we == it.we, it.tag, "rf_we", 64'(rf_we), 64'(it.we));
        if (it.we) begin
          chk(rf_idx == it.idx, it.tag, "rf_idx", 64'(rf_idx), 64'(it.idx));
          chk(rf_data == it.data, it.tag, "rf_data", rf_data, it.data);
        end
        chk(flt_code == it.flt, it.tag, "flt_code", 64'(flt_code), 64'(it.flt));
        if (it.flt == 2'd2)
          chk(flt_addr == it.faddr, it.tag, "flt_addr", 64'(flt_addr), 64'(it.faddr));
        chk(mem[it.wi] == it.mword, it.tag, "memory word", mem[it.wi], it.mword);
        chk((n_req - base_req) == it.reqs, it.tag, "requests",
            64'(n_req - base_req), 64'(it.reqs));
        chk((n_wr - base_wr) == it.wrs, it.tag, "writes",
            64'(n_wr - base_wr), 64'(it.wrs));
        if (it.wrs != 0)
          chk(last_be == it.be, it.tag, "byte enables", 64'(last_be), 64'(it.be));
      end
      base_req = n_req;
      base_wr  = n_wr;
    end
  end

  task automatic preload(input int i, input logic [63:0] v);
    mem[i]     = v;
    ref_mem[i] = v;
  endtask

  task automatic run_op(input logic [2:0] op, input bit word, input logic [31:0] addr,
                        input logic [63:0] opnd, input logic [63:0] cmp,
                        input logic [5:0] dst, input bit rerr, input bit werr,
                        input logic [1:0] stall, input string tag);
    item_t it;
    logic [3:0]  wi;
    logic [63:0] raw, old, nv, s;
    logic        wr, mis;
    wi  = addr[6:3];
    mis = word ? (addr[1:0] != 2'b00) : (addr[2:0] != 3'b000);
    it.tag = tag; it.wi = wi; it.faddr = addr; it.idx = dst;
    it.we = 1'b0; it.flt = 2'd0; it.reqs = 0; it.wrs = 0; it.data = '0;
    it.be = word ? (addr[2] ? 8'hF0 : 8'h0F) : 8'hFF;
    if (mis) begin
      it.flt = 2'd1;
    end else if (rerr) begin
      it.flt = 2'd2; it.reqs = 1;
    end else begin
      raw = ref_mem[wi];
      if (word) old = addr[2] ? {{32{raw[63]}}, raw[63:32]} : {{32{raw[31]}}, raw[31:0]};
      else old = raw;
      nv = old; wr = 1'b0;
      s  = old + opnd;
      case (op)
        3'd0: begin nv = opnd; wr = 1'b1; end
        3'd1: begin nv = opnd; wr = word ? (old[31:0] == cmp[31:0]) : (old == cmp); end
        3'd2: begin nv = s; wr = 1'b1; end
        3'd3: begin nv = s; wr = word ? !s[31] : !s[63]; end
        3'd4: begin nv = old & opnd; wr = 1'b1; end
        3'd5: begin nv = old | opnd; wr = 1'b1; end
        default: wr = 1'b0;
      endcase
      it.data = old;
      it.reqs = wr ? 2 : 1;
      if (wr && werr) begin
        it.flt = 2'd2;
      end else begin
        if (wr) begin
          it.wrs = 1;
          if (!word) ref_mem[wi] = nv;
          else if (addr[2]) ref_mem[wi][63:32] = nv[31:0];
          else ref_mem[wi][31:0] = nv[31:0];
        end
        if (dst < NG) it.we = 1'b1;
        else if (dst < 62) it.flt = 2'd3;
      end
    end
    it.mword = ref_mem[wi];
    q.push_back(it);

    @(negedge clk);
    cmd_op = op; cmd_word = word; cmd_addr = addr; cmd_opnd = opnd;
    cmd_cmp = cmp; cmd_dst = dst; inj_rerr = rerr; inj_werr = werr;
    stall_cfg = stall; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk(busy && !cmd_ready, "R10", "busy after accept", 64'({busy, cmd_ready}), 64'h2);
    // a rival command held while busy must be refused
    cmd_op = 3'd0; cmd_word = 1'b0; cmd_addr = 32'h40; cmd_opnd = '1; cmd_dst = 6'd1;
    while (!done) @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    inj_rerr = 1'b0; inj_werr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      preload(i, {32'hA5A5_0000 | 32'(i), 32'h0000_1000 + 32'(i)});
    repeat (3) @(negedge clk);
    chk(cmd_ready && !busy && !mem_req && !done, "R1", "reset state",
        64'({cmd_ready, busy, mem_req, done}), 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy && !mem_req && !done, "R1", "idle after reset",
        64'({cmd_ready, busy, mem_req, done}), 64'h8);

    run_op(3'd0, 0, 32'h08, 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 6'd5, 0, 0, 2'd0, "R2 R3 swap64");
    preload(2, 64'h64);
    run_op(3'd1, 0, 32'h10, 64'h77, 64'h64, 6'd6, 0, 0, 2'd1, "R3 cas64 hit");
    run_op(3'd1, 0, 32'h10, 64'h99, 64'h64, 6'd6, 0, 0, 2'd0, "R3 cas64 miss");
    preload(3, 64'h8000_0001_1234_5678);
    run_op(3'd1, 1, 32'h1C, 64'h2222, 64'hFFFF_FFFF_8000_0001, 6'd7, 0, 0, 2'd2, "R2 R3 R6 cas32 hi");
    run_op(3'd1, 1, 32'h18, 64'h3333, 64'h0000_0001_1234_5678, 6'd8, 0, 0, 2'd0, "R3 cas32 lo");
    preload(4, 64'd100);
    run_op(3'd2, 0, 32'h20, 64'd5, 64'h0, 6'd9, 0, 0, 2'd3, "R4 add64");
    run_op(3'd2, 1, 32'h24, 64'hFFFF_FFFF, 64'h0, 6'd10, 0, 0, 2'd0, "R4 R6 add32 hi");
    preload(5, 64'hF0F0_F0F0_8F0F_F0F0);
    run_op(3'd4, 0, 32'h28, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 6'd11, 0, 0, 2'd0, "R4 and64");
    run_op(3'd5, 1, 32'h28, 64'h0000_000F, 64'h0, 6'd12, 0, 0, 2'd1, "R2 R4 R6 or32 lo");
    run_op(3'd6, 0, 32'h28, 64'h1234, 64'h0, 6'd13, 0, 0, 2'd0, "R4 reserved code");
    preload(6, 64'd10);
    run_op(3'd3, 0, 32'h30, 64'hFFFF_FFFF_FFFF_FFEC, 64'h0, 6'd14, 0, 0, 2'd0, "R5 gez64 negative");
    run_op(3'd3, 0, 32'h30, 64'hFFFF_FFFF_FFFF_FFF6, 64'h0, 6'd15, 0, 0, 2'd0, "R5 gez64 zero");
    preload(7, 64'h0000_0000_7FFF_FFF0);
    run_op(3'd3, 1, 32'h38, 64'h20, 64'h0, 6'd16, 0, 0, 2'd0, "R5 gez32 bit31");
    run_op(3'd3, 1, 32'h38, 64'h05, 64'h0, 6'd16, 0, 0, 2'd0, "R5 gez32 positive");
    run_op(3'd0, 1, 32'h3A, 64'h1, 64'h0, 6'd17, 0, 0, 2'd0, "R7 misaligned32");
    run_op(3'd2, 0, 32'h34, 64'h1, 64'h0, 6'd18, 0, 0, 2'd0, "R7 misaligned64");
    run_op(3'd0, 0, 32'h40, 64'h5555, 64'h0, 6'd19, 1, 0, 2'd1, "R8 read error");
    run_op(3'd5, 0, 32'h48, 64'hFF00, 64'h0, 6'd20, 0, 1, 2'd0, "R8 write error");
    run_op(3'd2, 0, 32'h48, 64'h1, 64'h0, 6'd21, 0, 0, 2'd0, "R8 recovery");
    run_op(3'd0, 0, 32'h50, 64'hAAAA, 64'h0, 6'd63, 0, 0, 2'd0, "R9 zero register");
    run_op(3'd0, 1, 32'h54, 64'hBBBB, 64'h0, 6'd62, 0, 0, 2'd0, "R9 sink register");
    run_op(3'd2, 0, 32'h58, 64'h7, 64'h0, 6'd58, 0, 0, 2'd0, "R9 network index");
    run_op(3'd0, 0, 32'h58, 64'h0, 64'h0, 6'd55, 0, 0, 2'd0, "R9 last gpr");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11", "pending results", 64'(q.size()), 64'd0);
    chk(cmd_ready && !busy, "R1", "idle at end", 64'({cmd_ready, busy}), 64'h2);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule